// File: doc/BRIEF.md
# Modulo-15 Loadable Binary Counter

This block is a synchronous binary counter with a parallel load, two count enables and a carry output. A comparator watches the count and drives an active-low match signal when the count reaches a chosen terminal value. That signal feeds the counter's own synchronous clear. With the default terminal value of 14, the counter runs 0, 1, ..., 14 and then returns to 0, so its cycle is 15 states long.

All control inputs are sampled on the rising clock edge. The clear has the highest priority. The load comes next, and counting comes last. The counter counts only when both enables are high. The carry output reports the all-ones count and is gated by one of the two enables. An external load can place the counter in a state past the terminal value, for example 15. From such a state the counter keeps counting and wraps through 0.

Top module: `mod15_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `q` becomes 0 after that edge.
- R2: When `clear_n` is low at a rising edge, `q` becomes 0. This holds whatever `load_n`, `cnt_en_t`, `cnt_en_p` and `din` are.
- R3: When `clear_n` is high, `load_n` is low and no wrap applies, `q` takes the value of `din` at the edge.
- R4: When clear and load are both inactive and either `cnt_en_t` or `cnt_en_p` is low, `q` keeps its value.
- R5: When clear and load are both inactive and both enables are high, `q` goes to `q+1` modulo 2^WIDTH. This means 15 is followed by 0.
- R6: `wrap_n` is low exactly when `q` equals the terminal value. The default terminal value is 14 (binary 1110).
- R7: When `q` equals the terminal value at an edge, `q` is 0 after that edge. This holds even if a load is requested or the enables are low in that cycle.
- R8: If the counter starts at 0 and counts without interruption, it passes through 0..14 in order and returns to 0 after exactly 15 edges.
- R9: `carry_out` equals `cnt_en_t` when `q` is all ones (15), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_n | input | 1 | Synchronous active-low clear, highest priority |
| load_n | input | 1 | Synchronous active-low parallel load |
| cnt_en_t | input | 1 | Count enable that also gates the carry |
| cnt_en_p | input | 1 | Second count enable |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High when the count is all ones and `cnt_en_t` is high |
| wrap_n | output | 1 | Low while the count equals the terminal value |

## Verification
Two functions can fall in the same cycle: the terminal-value wrap and a parallel load. The bench loads a value, counts up to 14, and asserts `load_n` with fresh data in exactly that cycle. The cycle is judged correct only if the next count is 0 and not the data. A second collision drives `clear_n` and `load_n` low together, and the result must again be 0. The bench also loads 15 and checks that the count steps through 0 with the carry visible for one cycle.

// File: rtl/cnt_pkg.sv
// Shared types for the modulo counter: the action chosen at each edge.
package cnt_pkg;
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_COUNT = 2'd2,
        ACT_HOLD  = 2'd3
    } cnt_act_e;
endpackage

// File: rtl/cnt_core.sv
// Counter register with prioritised controls: clear, then load, then count.
// Assumes clr_n already merges the external clear and any wrap feedback.
module cnt_core
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_t,
    input  logic             en_p,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_act_e act;

    // Select the action for this edge by priority.
    always_comb begin
        if (!clr_n)             act = ACT_CLEAR;
        else if (!load_n)       act = ACT_LOAD;
        else if (en_t && en_p)  act = ACT_COUNT;
        else                    act = ACT_HOLD;
    end

    // Update the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (act)
                ACT_CLEAR: q <= '0;
                ACT_LOAD:  q <= din;
                ACT_COUNT: q <= q + ONE;
                default:   q <= q;
            endcase
        end
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (q == '0));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (q == '0));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> (q == $past(din)));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && !(en_t && en_p)) |=> $stable(q));
    p_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && en_t && en_p) |=> (q == WIDTH'($past(q) + ONE)));
endmodule

// File: rtl/term_match.sv
// Active-low decode of one terminal count value, one bit comparison per bit.
// Assumes TERM fits in WIDTH bits.
module term_match #(
    parameter int WIDTH = 4,
    parameter int TERM  = 14
) (
    input  logic [WIDTH-1:0] q,
    output logic             hit_n
);
    localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

    logic [WIDTH-1:0] bit_eq;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Compare one count bit with the terminal pattern.
        assign bit_eq[i] = (q[i] == TERM_V[i]);
    end

    // Go low only when every bit matches.
    assign hit_n = ~(&bit_eq);
endmodule

// File: rtl/carry_gen.sv
// Carry output: reports the all-ones count, gated by the carry enable.
module carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry
);
    // Full-count detect gated by the enable.
    assign carry = en_t & (&q);
endmodule

// File: rtl/mod15_counter.sv
// Top: loadable binary counter whose terminal-state decode feeds its own
// synchronous clear, shortening the cycle to TERM+1 states.
// Assumes all inputs are synchronous to clk.
module mod15_counter #(
    parameter int WIDTH = 4,
    parameter int TERM  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cnt_en_t,
    input  logic             cnt_en_p,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out,
    output logic             wrap_n
);
    localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

    logic clr_eff_n;

    // Merge the external clear with the wrap feedback.
    assign clr_eff_n = clear_n & wrap_n;

    cnt_core #(.WIDTH(WIDTH)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_eff_n),
        .load_n (load_n),
        .en_t   (cnt_en_t),
        .en_p   (cnt_en_p),
        .din    (din),
        .q      (q)
    );

    term_match #(.WIDTH(WIDTH), .TERM(TERM)) i_match (
        .q     (q),
        .hit_n (wrap_n)
    );

    carry_gen #(.WIDTH(WIDTH)) i_carry (
        .q     (q),
        .en_t  (cnt_en_t),
        .carry (carry_out)
    );

    p_wrap_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q == TERM_V) |=> (q == '0));
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_n |-> (q == TERM_V));
    p_carry_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> ((&q) && cnt_en_t));
endmodule

// File: tb/test_mod15_counter.sv
// Bench for mod15_counter.
// A behavioural reference model advances in step with the design, and the
// outputs are compared on every clock.
module test_mod15_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_n = 1'b1;
    logic       load_n = 1'b1;
    logic       cnt_en_t = 1'b0;
    logic       cnt_en_p = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       carry_out;
    logic       wrap_n;

    int errors = 0;
    int checks = 0;
    int exp_q  = 0;
    bit done   = 1'b0;
    int hist[$];

    mod15_counter i_mod15_counter (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
        .cnt_en_t(cnt_en_t), .cnt_en_p(cnt_en_p), .din(din),
        .q(q), .carry_out(carry_out), .wrap_n(wrap_n)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply inputs, advance the model by one edge, then compare all outputs.
    task automatic step(string tag, bit c, bit l, bit t, bit p, int d);
        int nxt;
        clear_n = c; load_n = l; cnt_en_t = t; cnt_en_p = p; din = 4'(d);
        if (!c || exp_q == 14)  nxt = 0;
        else if (!l)            nxt = d;
        else if (t && p)        nxt = (exp_q + 1) % 16;
        else                    nxt = exp_q;
        @(posedge clk);
        @(negedge clk);
        exp_q = nxt;
        check(tag, int'(q), exp_q);
        check("R6 wrap_n", int'(wrap_n), (exp_q == 14) ? 0 : 1);
        check("R9 carry_out", int'(carry_out), (exp_q == 15 && t) ? 1 : 0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'(q), 0);
        rst_n = 1'b1;
        exp_q = 0;

        // R3: plain load.
        step("R3 load", 1, 0, 0, 0, 9);
        // R4: hold with each enable low in turn.
        step("R4 hold t=0", 1, 1, 0, 1, 0);
        step("R4 hold p=0", 1, 1, 1, 0, 0);
        // R5: increment.
        step("R5 incr", 1, 1, 1, 1, 0);
        // R2: clear beats load.
        step("R2 clear over load", 0, 0, 1, 1, 7);
        // R8: full cycle from 0, recording each state.
        hist.delete();
        for (int i = 0; i < 15; i++) begin
            hist.push_back(int'(q));
            step("R8 sequence", 1, 1, 1, 1, 0);
        end
        for (int i = 0; i < 15; i++) check("R8 order", hist[i], i);
        check("R8 period", int'(q), 0);

        // R7: wrap beats load and low enables.
        step("R3 load 13", 1, 0, 1, 1, 13);
        step("R5 to 14", 1, 1, 1, 1, 0);
        step("R7 wrap over load", 1, 0, 1, 1, 5);
        step("R3 load 14", 1, 0, 0, 0, 14);
        step("R7 wrap enables low", 1, 1, 0, 0, 0);

        // R9/R5: load 15, show carry, then roll to 0.
        step("R3 load 15", 1, 0, 1, 0, 15);
        step("R4 hold 15", 1, 1, 0, 1, 0);
        step("R5 15 to 0", 1, 1, 1, 1, 0);

        // R2: clear with enables high.
        step("R5 incr", 1, 1, 1, 1, 0);
        step("R2 clear", 0, 1, 1, 1, 0);

        // R1: reset mid-count.
        step("R5 incr", 1, 1, 1, 1, 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-count", int'(q), 0);
        rst_n = 1'b1;
        exp_q = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule